// File: doc/BRIEF.md
# Rendering VRAM Address Sequencer

This block advances the picture unit's current VRAM address while the background is being drawn. Each clock it takes the current address `v`, the temporary address `t`, the dot and scanline position, a pre-render line flag, a rendering-enabled flag and a one-cycle data-port access pulse. From these it computes the address that `v` must hold next. Dot-timed events are coarse X steps, the fine/coarse Y step, and the horizontal and vertical reloads from `t`.

The block also derives the nametable tile fetch address and the attribute fetch address from the incoming `v`. All three results are registered and appear one clock after the inputs that produced them. The owner of the `v` register loads `v_next_o` back into `v`.

In the 15-bit address, bits 4:0 hold coarse X, bits 9:5 hold coarse Y, bit 10 selects the horizontal nametable, bit 11 selects the vertical nametable, and bits 14:12 hold fine Y. A "rendering line" is any line where the pre-render flag is high or the scanline number is at most 239. Dot-timed actions and port-access effects apply only on a rendering line with rendering enabled.

Top module: `vram_addr_seq`

## Requirements
- R1: A coarse X step adds one to v[4:0]. From 31 it goes to 0 instead and inverts v[10], leaving all other bits alone.
- R2: A Y step adds one to fine Y v[14:12] when it is below 7. At 7, fine Y becomes 0 and a carry goes into coarse Y.
- R3: On a carry, coarse Y of 29 becomes 0 and inverts v[11]. Coarse Y of 31 becomes 0 with v[11] kept. Any other coarse Y value adds one.
- R4: On a rendering line, a Y step is applied at dot 256.
- R5: On a rendering line at dot 257, v[10] and v[4:0] are loaded from t. A copy takes precedence over any step on the same bits.
- R6: On the pre-render line, at every dot from 280 to 304 inclusive, v[14:11] and v[9:5] are loaded from t. Dots 279 and 305 do not load.
- R7: On a rendering line, coarse X steps at dots 328 and 336 and at every multiple of 8 from 8 to 256. No other dot steps coarse X.
- R8: A port access on a rendering line applies both a coarse X step and a Y step. On a non-rendering line (scanline 240 or above, pre-render flag low) the access leaves v unchanged.
- R9: A port access in the same cycle as a scheduled coarse X or Y step advances each counter only once.
- R10: With rendering disabled, v_next_o equals the incoming v whatever the dot, line or access inputs.
- R11: The tile fetch address is 0x2000 OR v[11:0].
- R12: The attribute fetch address is 0x23C0 OR (v AND 0x0C00) OR ((v>>4) AND 0x38) OR ((v>>2) AND 0x07).
- R13: Outputs are registered. They reflect the inputs of the previous clock edge, and reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_i | input | 9 | Dot number within the line |
| line_i | input | 9 | Scanline number |
| prerender_i | input | 1 | High on the pre-render line |
| render_en_i | input | 1 | Rendering enabled |
| t_i | input | 15 | Temporary address |
| v_i | input | 15 | Current address |
| access_i | input | 1 | Data-port access pulse |
| v_next_o | output | 15 | Next value of the current address |
| tile_addr_o | output | 14 | Nametable tile fetch address |
| attr_addr_o | output | 14 | Attribute fetch address |

## Verification
A port access can fall in the same cycle as a scheduled coarse X step (dot 8) or as the dot-256 step that moves both counters. The access can also coincide with the dot-257 horizontal reload. Directed cases drive the access pulse on exactly those dots from a zero address. They expect 0x1001 rather than a double advance, and at dot 257 they expect the copied horizontal bits with only the Y step kept. Random stimulus sets the access pulse at about one cycle in eight over all dots, so further overlaps occur, each judged against the bench's own model.

// File: rtl/vas_pkg.sv
package vas_pkg;
    localparam int V_W    = 15;
    localparam int ADDR_W = 14;

    // field positions inside the address word
    localparam int CX_LO = 0;
    localparam int CX_HI = 4;
    localparam int CY_LO = 5;
    localparam int CY_HI = 9;
    localparam int NT_H  = 10;
    localparam int NT_V  = 11;
    localparam int FY_LO = 12;
    localparam int FY_HI = 14;

    localparam int CX_W = CX_HI - CX_LO + 1;
    localparam int CY_W = CY_HI - CY_LO + 1;
    localparam int FY_W = FY_HI - FY_LO + 1;

    localparam logic [CY_W-1:0] LAST_ROW = CY_W'(29);

    typedef struct packed {
        logic [V_W-1:0]    v_next;
        logic [ADDR_W-1:0] tile;
        logic [ADDR_W-1:0] attr;
    } vas_out_t;
endpackage

// File: rtl/vas_xstep.sv
module vas_xstep
    import vas_pkg::*;
(
    input  logic [V_W-1:0] v_in,
    output logic [V_W-1:0] v_out
);
    always_comb begin
        v_out = v_in;
        if (v_in[CX_HI:CX_LO] == {CX_W{1'b1}}) begin
            v_out[CX_HI:CX_LO] = '0;
            v_out[NT_H]        = ~v_in[NT_H];
        end else begin
            v_out[CX_HI:CX_LO] = v_in[CX_HI:CX_LO] + CX_W'(1);
        end
    end
endmodule

// File: rtl/vas_ystep.sv
module vas_ystep
    import vas_pkg::*;
(
    input  logic [V_W-1:0] v_in,
    output logic [V_W-1:0] v_out
);
    logic [CY_W-1:0] row;

    always_comb begin
        v_out = v_in;
        row   = v_in[CY_HI:CY_LO];
        if (v_in[FY_HI:FY_LO] != {FY_W{1'b1}}) begin
            v_out[FY_HI:FY_LO] = v_in[FY_HI:FY_LO] + FY_W'(1);
        end else begin
            v_out[FY_HI:FY_LO] = '0;
            if (row == LAST_ROW) begin
                row         = '0;
                v_out[NT_V] = ~v_in[NT_V];
            end else if (row == {CY_W{1'b1}}) begin
                row = '0;
            end else begin
                row = row + CY_W'(1);
            end
            v_out[CY_HI:CY_LO] = row;
        end
    end
endmodule

// File: rtl/vas_fetch.sv
module vas_fetch
    import vas_pkg::*;
(
    input  logic [V_W-1:0]    v_in,
    output logic [ADDR_W-1:0] tile_addr,
    output logic [ADDR_W-1:0] attr_addr
);
    always_comb begin
        tile_addr = {2'b10, v_in[NT_V:0]};
        attr_addr = {2'b10, v_in[NT_V:NT_H], 4'b1111,
                     v_in[CY_HI:CY_HI-2], v_in[CX_HI:CX_HI-2]};
    end
endmodule

// File: rtl/vram_addr_seq.sv
module vram_addr_seq
    import vas_pkg::*;
#(
    parameter int DOT_W       = 9,
    parameter int LINE_W      = 9,
    parameter int LAST_VIS    = 239,
    parameter int Y_DOT       = 256,
    parameter int HCOPY_DOT   = 257,
    parameter int VCOPY_FIRST = 280,
    parameter int VCOPY_LAST  = 304,
    parameter int PRE_DOT_A   = 328,
    parameter int PRE_DOT_B   = 336,
    parameter int X_STEP      = 8,
    parameter int X_LAST      = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              prerender_i,
    input  logic              render_en_i,
    input  logic [V_W-1:0]    t_i,
    input  logic [V_W-1:0]    v_i,
    input  logic              access_i,
    output logic [V_W-1:0]    v_next_o,
    output logic [ADDR_W-1:0] tile_addr_o,
    output logic [ADDR_W-1:0] attr_addr_o
);
    localparam logic [DOT_W-1:0]  D_Y   = DOT_W'(Y_DOT);
    localparam logic [DOT_W-1:0]  D_H   = DOT_W'(HCOPY_DOT);
    localparam logic [DOT_W-1:0]  D_V0  = DOT_W'(VCOPY_FIRST);
    localparam logic [DOT_W-1:0]  D_V1  = DOT_W'(VCOPY_LAST);
    localparam logic [DOT_W-1:0]  D_PA  = DOT_W'(PRE_DOT_A);
    localparam logic [DOT_W-1:0]  D_PB  = DOT_W'(PRE_DOT_B);
    localparam logic [DOT_W-1:0]  D_XS  = DOT_W'(X_STEP);
    localparam logic [DOT_W-1:0]  D_XL  = DOT_W'(X_LAST);
    localparam logic [LINE_W-1:0] L_VIS = LINE_W'(LAST_VIS);

    logic active, x_sched, do_x, do_y, hcopy, vcopy;
    logic [V_W-1:0] v_xs, v_after_x, v_ys, v_after_y;
    logic [ADDR_W-1:0] tile_w, attr_w;
    vas_out_t out_d, out_q;

    // schedule decode
    always_comb begin
        active  = render_en_i && (prerender_i || (line_i <= L_VIS));
        x_sched = (dot_i == D_PA) || (dot_i == D_PB) ||
                  ((dot_i % D_XS) == '0 && dot_i >= D_XS && dot_i <= D_XL);
        // an access merges into the same enables: one step per counter
        do_x    = active && (x_sched || access_i);
        do_y    = active && ((dot_i == D_Y) || access_i);
        hcopy   = active && (dot_i == D_H);
        vcopy   = active && prerender_i && dot_i >= D_V0 && dot_i <= D_V1;
    end

    vas_xstep u_xstep (.v_in(v_i), .v_out(v_xs));

    always_comb v_after_x = do_x ? v_xs : v_i;

    vas_ystep u_ystep (.v_in(v_after_x), .v_out(v_ys));

    always_comb v_after_y = do_y ? v_ys : v_after_x;

    vas_fetch u_fetch (.v_in(v_i), .tile_addr(tile_w), .attr_addr(attr_w));

    always_comb begin
        out_d        = out_q;
        out_d.v_next = v_after_y;
        if (hcopy) begin
            out_d.v_next[NT_H]        = t_i[NT_H];
            out_d.v_next[CX_HI:CX_LO] = t_i[CX_HI:CX_LO];
        end
        if (vcopy) begin
            out_d.v_next[FY_HI:NT_V]  = t_i[FY_HI:NT_V];
            out_d.v_next[CY_HI:CY_LO] = t_i[CY_HI:CY_LO];
        end
        out_d.tile = tile_w;
        out_d.attr = attr_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign v_next_o    = out_q.v_next;
    assign tile_addr_o = out_q.tile;
    assign attr_addr_o = out_q.attr;

    // one cycle after reset release the outputs track past inputs
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(active) |-> v_next_o == $past(v_i));

    assert_x_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(do_x) && !$past(hcopy) |->
            v_next_o[CX_HI:CX_LO] == $past(v_i[CX_HI:CX_LO]) &&
            v_next_o[NT_H] == $past(v_i[NT_H]));

    assert_hcopy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(hcopy) |->
            v_next_o[CX_HI:CX_LO] == $past(t_i[CX_HI:CX_LO]) &&
            v_next_o[NT_H] == $past(t_i[NT_H]));

    assert_vcopy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(vcopy) |->
            v_next_o[FY_HI:NT_V] == $past(t_i[FY_HI:NT_V]) &&
            v_next_o[CY_HI:CY_LO] == $past(t_i[CY_HI:CY_LO]));

    assert_fine_y_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(do_y) && !$past(vcopy) |->
            v_next_o[FY_HI:FY_LO] == $past(v_i[FY_HI:FY_LO]) + FY_W'(1));

    assert_tile_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> tile_addr_o == {2'b10, $past(v_i[NT_V:0])});
endmodule

// File: tb/vram_addr_seq_tb.sv
module vram_addr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  dot = '0;
    logic [8:0]  line = '0;
    logic        pre = 1'b0;
    logic        ren = 1'b0;
    logic [14:0] t = '0;
    logic [14:0] v = '0;
    logic        acc = 1'b0;
    logic [14:0] v_next;
    logic [13:0] tile, attr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    vram_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .dot_i(dot), .line_i(line),
        .prerender_i(pre), .render_en_i(ren), .t_i(t), .v_i(v),
        .access_i(acc), .v_next_o(v_next), .tile_addr_o(tile),
        .attr_addr_o(attr)
    );

    function automatic logic [14:0] m_x(input logic [14:0] a);
        if (a[4:0] == 5'd31) return (a & 15'h7FE0) ^ 15'h0400;
        return a + 15'd1;
    endfunction

    function automatic logic [14:0] m_y(input logic [14:0] a);
        logic [4:0] r;
        if (a[14:12] != 3'd7) return a + 15'h1000;
        a = a & 15'h0FFF;
        r = a[9:5];
        if (r == 5'd29) begin r = 0; a = a ^ 15'h0800; end
        else if (r == 5'd31) r = 0;
        else r = r + 5'd1;
        return (a & 15'h7C1F) | ({10'd0, r} << 5);
    endfunction

    function automatic logic [14:0] m_next(input int d, input int l, input logic p,
            input logic r, input logic [14:0] tt, input logic [14:0] vv, input logic a);
        logic on, xs;
        if (!(r && (p || l <= 239))) return vv;
        on = 1'b1;
        xs = (d == 328) || (d == 336) || (d % 8 == 0 && d >= 8 && d <= 256);
        if (on && (xs || a)) vv = m_x(vv);
        if (on && (d == 256 || a)) vv = m_y(vv);
        if (d == 257) vv = (vv & 15'h7BE0) | (tt & 15'h041F);
        if (p && d >= 280 && d <= 304) vv = (vv & 15'h041F) | (tt & 15'h7BE0);
        return vv;
    endfunction

    function automatic logic [13:0] m_attr(input logic [14:0] a);
        logic [15:0] w;
        w = 16'h23C0 | ({1'b0, a} & 16'h0C00) | (({1'b0, a} >> 4) & 16'h0038)
            | (({1'b0, a} >> 2) & 16'h0007);
        return w[13:0];
    endfunction

    task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at posedge+1, the result is registered at the next edge
    task automatic step(input int d, input int l, input logic p, input logic r,
            input logic [14:0] tt, input logic [14:0] vv, input logic a);
        dot = 9'(d); line = 9'(l); pre = p; ren = r; t = tt; v = vv; acc = a;
        @(posedge clk); #1;
    endtask

    task automatic dv(input string req, input int d, input int l, input logic p,
            input logic r, input logic [14:0] tt, input logic [14:0] vv,
            input logic a, input logic [14:0] exp);
        step(d, l, p, r, tt, vv, a);
        chk(req, v_next, exp);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog R13 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R13 reset v", v_next, 15'h0);
        chk("R13 reset tile", {1'b0, tile}, 15'h0);
        chk("R13 reset attr", {1'b0, attr}, 15'h0);
        rst_n = 1'b1;

        dv("R1 wrap 31", 8, 10, 0, 1, 0, 15'h001F, 0, 15'h0400);
        dv("R1 wrap back", 16, 10, 0, 1, 0, 15'h041F, 0, 15'h0000);
        dv("R3 row29", 256, 10, 0, 1, 0, 15'h73A0, 0, 15'h0801);
        dv("R3 row31", 256, 10, 0, 1, 0, 15'h73E0, 0, 15'h0001);
        dv("R3 row30", 256, 10, 0, 1, 0, 15'h73C0, 0, 15'h03E1);
        dv("R2 R4 fine", 256, 10, 0, 1, 0, 15'h2000, 0, 15'h3001);
        dv("R5 hcopy", 257, 10, 0, 1, 15'h7FFF, 15'h0000, 0, 15'h041F);
        dv("R6 first", 280, 261, 1, 1, 15'h7BE0, 15'h041F, 0, 15'h7FFF);
        dv("R6 last", 304, 261, 1, 1, 15'h7BE0, 15'h041F, 0, 15'h7FFF);
        dv("R6 after", 305, 261, 1, 1, 15'h7BE0, 15'h041F, 0, 15'h041F);
        dv("R6 before", 279, 261, 1, 1, 15'h7BE0, 15'h041F, 0, 15'h041F);
        dv("R6 visible line", 290, 10, 0, 1, 15'h7BE0, 15'h041F, 0, 15'h041F);
        dv("R7 dot328", 328, 10, 0, 1, 0, 15'h0005, 0, 15'h0006);
        dv("R7 dot336", 336, 10, 0, 1, 0, 15'h0005, 0, 15'h0006);
        dv("R7 dot264", 264, 10, 0, 1, 0, 15'h0005, 0, 15'h0005);
        dv("R7 dot0", 0, 10, 0, 1, 0, 15'h0005, 0, 15'h0005);
        dv("R7 dot7", 7, 10, 0, 1, 0, 15'h0005, 0, 15'h0005);
        dv("R8 access", 3, 100, 0, 1, 0, 15'h0000, 1, 15'h1001);
        dv("R8 access pre", 3, 261, 1, 1, 0, 15'h0000, 1, 15'h1001);
        dv("R8 access line240", 3, 240, 0, 1, 0, 15'h0000, 1, 15'h0000);
        dv("R9 dot256", 256, 100, 0, 1, 0, 15'h0000, 1, 15'h1001);
        dv("R9 dot8", 8, 100, 0, 1, 0, 15'h0000, 1, 15'h1001);
        dv("R9 R5 dot257", 257, 100, 0, 1, 15'h0003, 15'h0000, 1, 15'h1003);
        dv("R10 off access", 3, 100, 0, 0, 0, 15'h1234, 1, 15'h1234);
        dv("R10 off 256", 256, 100, 0, 0, 0, 15'h73A0, 0, 15'h73A0);
        dv("R10 off 257", 257, 100, 0, 0, 15'h7FFF, 15'h0000, 0, 15'h0000);
        dv("R10 off 290", 290, 261, 1, 0, 15'h7FFF, 15'h0000, 0, 15'h0000);
        step(3, 100, 0, 1, 0, 15'h1234, 0);
        chk("R11 tile", {1'b0, tile}, 15'h2234);
        chk("R12 attr", {1'b0, attr}, 15'h23E5);
        step(3, 300, 0, 0, 0, 15'h7FFF, 0);
        chk("R11 tile all", {1'b0, tile}, 15'h2FFF);
        chk("R12 attr all", {1'b0, attr}, 15'h2FFF);

        for (int i = 0; i < 3000; i++) begin
            int d, l;
            logic p, r, a;
            logic [14:0] tt, vv;
            case ($urandom_range(0, 3))
                0: d = $urandom_range(0, 340);
                1: d = 8 * $urandom_range(0, 42);
                2: d = $urandom_range(255, 258);
                default: d = $urandom_range(278, 306);
            endcase
            l  = $urandom_range(0, 261);
            p  = (l == 261);
            r  = ($urandom_range(0, 7) != 0);
            a  = ($urandom_range(0, 7) == 0);
            tt = 15'($urandom);
            vv = 15'($urandom);
            step(d, l, p, r, tt, vv, a);
            chk("R1-model R4 R7 R8", v_next, m_next(d, l, p, r, tt, vv, a));
            chk("R11 random", {1'b0, tile}, {1'b0, 2'b10, vv[11:0]});
            chk("R12 random", {1'b0, attr}, {1'b0, m_attr(vv)});
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule